// File: doc/BRIEF.md
# Taken-Branch Target Buffer Predictor

This block is the direction and target guesser at the front of an instruction pipeline. Only branches that have actually been taken are recorded. A lookup that finds no entry for the fetched address therefore predicts fall-through. The fetch stage presents an instruction address, a decoded branch class and the displacement carried in the instruction. The block answers in the same cycle with a taken/not-taken guess and a target. Relative branches get their target from address plus displacement. Register-target branches get theirs from the stored entry.

When a branch completes, the resolve port receives its real direction and target. It reports in the same cycle whether the earlier guess was wrong. It then updates the table at the next clock edge: a taken branch is allocated or refreshed, a register target that changed is overwritten, and a recorded branch that fell through is dropped. Two decode-known classes bypass the table completely. Unconditional branches are always guessed taken. The never-branching register form is always guessed not taken.

The table is set-associative with a parameterised entry count and way count. The set index is taken from the low address bits above the alignment bits, and the upper bits form the tag. Replacement inside a set is true least-recently-used.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset invalidates every entry, so after reset every lookup of a conditional class predicts not taken until a taken branch is resolved.
- R2: A conditional lookup that misses predicts not taken, and its target output is address plus displacement.
- R3: Resolving a conditional branch (class 2'b00 relative or 2'b01 register) as taken makes the next-cycle lookup of the same address predict taken.
- R4: A hit on the register class (2'b01) returns the stored target. A relative-class (2'b00) lookup always returns address plus displacement, and a relative resolve never flags a mispredict on target mismatch.
- R5: A taken register-class resolve that hits with a different target raises mispredict and overwrites the stored target. The same target raises no mispredict.
- R6: A not-taken conditional resolve that hits raises mispredict and invalidates the entry. A not-taken resolve that misses raises no mispredict and allocates nothing.
- R7: A taken conditional resolve that misses raises mispredict.
- R8: The always-taken class (2'b10) is predicted taken with target address plus displacement whatever the table holds. Its resolve flags mispredict only when not taken, and it never writes the table.
- R9: The never-taken class (2'b11) is predicted not taken even when the table holds a taken entry for that address. Its resolve flags mispredict only when taken, and it leaves the table unchanged.
- R10: Allocation fills an invalid way of the set first. Otherwise it evicts the way least recently allocated or confirmed by a taken resolve.
- R11: A lookup in the same cycle as an update to the same address sees the contents from before the update. The update is visible from the following cycle.
- R12: The mispredict output stays low while the resolve port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, invalidates the table |
| lk_valid | input | 1 | Lookup request valid |
| lk_pc | input | ADDR_W | Address of the fetched branch |
| lk_kind | input | 2 | Branch class: 00 cond relative, 01 cond register, 10 always, 11 never |
| lk_disp | input | ADDR_W | Displacement added to the address for computed targets |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | ADDR_W | Predicted target |
| rs_valid | input | 1 | Resolve request valid |
| rs_pc | input | ADDR_W | Address of the resolved branch |
| rs_kind | input | 2 | Class of the resolved branch, same encoding as lk_kind |
| rs_taken | input | 1 | Actual direction |
| rs_target | input | ADDR_W | Actual target |
| rs_mispredict | output | 1 | The prediction for this branch was wrong |

## Verification
The bench fills every set of a four-set, four-way table past capacity. It checks which address disappears when a fifth and a sixth tag arrive, and whether a confirming resolve in between changes that choice. A design with broken recency would evict the refreshed branch. A design that ignored invalid ways would throw away a live entry after an invalidation. Register targets are changed under a resident entry to catch a predictor that keeps the stale target or stays silent about it. The never-taken class is looked up on an address that holds a taken entry, which exposes a design that lets the table override decode. A lookup and an update to one address in the same cycle show whether the new contents leak into the current cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    BK_COND_REL = 2'b00,
    BK_COND_REG = 2'b01,
    BK_ALWAYS   = 2'b10,
    BK_NEVER    = 2'b11
  } br_kind_e;
endpackage

// File: rtl/btb_way.sv
// One way of the table: valid bits in flops, tag and target in RAM-style arrays.
module btb_way #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 256,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_tgt,
  input  logic [IDX_W-1:0]  rs_idx,
  input  logic [TAG_W-1:0]  rs_tag,
  output logic              rs_hit,
  output logic              rs_vld,
  output logic [ADDR_W-1:0] rs_tgt,
  input  logic              wr_en,
  input  logic              inv_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt
);
  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_mem [SETS];
  logic [ADDR_W-1:0] tgt_mem [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[rs_idx] <= 1'b1;
    end else if (inv_en) begin
      vld_q[rs_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[rs_idx] <= wr_tag;
      tgt_mem[rs_idx] <= wr_tgt;
    end
  end

  assign lk_hit = vld_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign lk_tgt = tgt_mem[lk_idx];
  assign rs_vld = vld_q[rs_idx];
  assign rs_hit = vld_q[rs_idx] && (tag_mem[rs_idx] == rs_tag);
  assign rs_tgt = tgt_mem[rs_idx];
endmodule

// File: rtl/btb_lru.sv
// Per-set age counters: 0 is most recent, WAYS-1 is the eviction candidate.
module btb_lru #(
  parameter int SETS  = 256,
  parameter int WAYS  = 4,
  parameter int IDX_W = 8,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way) begin
          age_q[idx][w] <= '0;
        end else if (age_q[idx][w] < age_q[idx][touch_way]) begin
          age_q[idx][w] <= age_q[idx][w] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_vec[w] && !found) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[idx][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 1024,
  parameter int WAYS    = 4,
  parameter int ALIGN_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic [1:0]        lk_kind,
  input  logic [ADDR_W-1:0] lk_disp,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic [1:0]        rs_kind,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  output logic              rs_mispredict
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [IDX_W-1:0]  lk_idx, rs_idx;
  logic [TAG_W-1:0]  lk_tag, rs_tag;
  logic [WAYS-1:0]   lk_hit_vec, rs_hit_vec, rs_vld_vec;
  logic [ADDR_W-1:0] lk_tgt_arr [WAYS];
  logic [ADDR_W-1:0] rs_tgt_arr [WAYS];
  logic              upd_wr, upd_inv, upd_touch;
  logic [WAY_W-1:0]  upd_way, victim_way, rs_hit_way;
  logic [ADDR_W-1:0] lk_hit_tgt, rs_hit_tgt;
  br_kind_e          lk_k, rs_k;
  logic              lk_pred;

  assign lk_idx = lk_pc[ALIGN_W +: IDX_W];
  assign lk_tag = lk_pc[ADDR_W-1 -: TAG_W];
  assign rs_idx = rs_pc[ALIGN_W +: IDX_W];
  assign rs_tag = rs_pc[ADDR_W-1 -: TAG_W];
  assign lk_k   = br_kind_e'(lk_kind);
  assign rs_k   = br_kind_e'(rs_kind);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic wr_sel, inv_sel;
    assign wr_sel  = upd_wr  && (upd_way == WAY_W'(w));
    assign inv_sel = upd_inv && (upd_way == WAY_W'(w));
    btb_way #(.ADDR_W(ADDR_W), .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
      .clk(clk), .rst(rst),
      .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit_vec[w]), .lk_tgt(lk_tgt_arr[w]),
      .rs_idx(rs_idx), .rs_tag(rs_tag), .rs_hit(rs_hit_vec[w]), .rs_vld(rs_vld_vec[w]),
      .rs_tgt(rs_tgt_arr[w]),
      .wr_en(wr_sel), .inv_en(inv_sel), .wr_tag(rs_tag), .wr_tgt(rs_target)
    );
  end

  btb_lru #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_lru (
    .clk(clk), .rst(rst), .idx(rs_idx), .valid_vec(rs_vld_vec),
    .touch_en(upd_touch), .touch_way(upd_way), .victim(victim_way)
  );

  // Hit-way selection for both ports
  always_comb begin
    lk_hit_tgt = '0;
    rs_hit_tgt = '0;
    rs_hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit_vec[w]) lk_hit_tgt = lk_hit_tgt | lk_tgt_arr[w];
      if (rs_hit_vec[w]) begin
        rs_hit_tgt = rs_hit_tgt | rs_tgt_arr[w];
        rs_hit_way = WAY_W'(w);
      end
    end
  end

  // Lookup port
  always_comb begin
    case (lk_k)
      BK_ALWAYS: lk_pred = 1'b1;
      BK_NEVER:  lk_pred = 1'b0;
      default:   lk_pred = |lk_hit_vec;
    endcase
  end

  assign lk_taken  = lk_valid && lk_pred;
  assign lk_target = (lk_k == BK_COND_REG && |lk_hit_vec) ? lk_hit_tgt : lk_pc + lk_disp;

  // Resolve port: mispredict and table update decision
  always_comb begin
    rs_mispredict = 1'b0;
    upd_wr        = 1'b0;
    upd_inv       = 1'b0;
    upd_touch     = 1'b0;
    upd_way       = victim_way;
    if (rs_valid) begin
      case (rs_k)
        BK_ALWAYS: rs_mispredict = !rs_taken;
        BK_NEVER:  rs_mispredict = rs_taken;
        default: begin
          if (rs_taken) begin
            upd_wr    = 1'b1;
            upd_touch = 1'b1;
            if (|rs_hit_vec) begin
              upd_way       = rs_hit_way;
              rs_mispredict = (rs_k == BK_COND_REG) && (rs_hit_tgt != rs_target);
            end else begin
              rs_mispredict = 1'b1;
            end
          end else if (|rs_hit_vec) begin
            upd_way       = rs_hit_way;
            upd_inv       = 1'b1;
            rs_mispredict = 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_pc,
  input logic [1:0]        lk_kind,
  input logic              lk_taken,
  input logic [ADDR_W-1:0] lk_target,
  input logic              rs_valid,
  input logic [ADDR_W-1:0] rs_pc,
  input logic [1:0]        rs_kind,
  input logic              rs_taken,
  input logic [ADDR_W-1:0] rs_target,
  input logic              rs_mispredict,
  input logic [WAYS-1:0]   lk_hit_vec,
  input logic [WAYS-1:0]   rs_hit_vec
);
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && lk_valid && !lk_kind[1] |-> !lk_taken);

  assert_alloc_visible_R3: assert property (@(posedge clk) disable iff (rst)
    rs_valid && rs_taken && !rs_kind[1]
    |=> !(lk_valid && lk_pc == $past(rs_pc) && !lk_kind[1]) || lk_taken);

  assert_reg_same_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    lk_valid && rs_valid && lk_pc == rs_pc && lk_kind == 2'b01 && rs_kind == 2'b01
    |-> rs_mispredict == ((lk_taken != rs_taken) || (rs_taken && lk_target != rs_target)));

  assert_target_overwrite_R5: assert property (@(posedge clk) disable iff (rst)
    rs_valid && rs_taken && rs_kind == 2'b01
    |=> !(lk_valid && lk_pc == $past(rs_pc) && lk_kind == 2'b01) || lk_target == $past(rs_target));

  assert_invalidate_R6: assert property (@(posedge clk) disable iff (rst)
    rs_valid && !rs_taken && !rs_kind[1]
    |=> !(lk_valid && lk_pc == $past(rs_pc) && !lk_kind[1]) || !lk_taken);

  assert_rel_same_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    lk_valid && rs_valid && lk_pc == rs_pc && lk_kind == 2'b00 && rs_kind == 2'b00
    |-> rs_mispredict == (lk_taken != rs_taken));

  assert_always_taken_R8: assert property (@(posedge clk) disable iff (rst)
    lk_valid && lk_kind == 2'b10 |-> lk_taken);

  assert_never_taken_R9: assert property (@(posedge clk) disable iff (rst)
    lk_valid && lk_kind == 2'b11 |-> !lk_taken);

  assert_single_hit_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_vec) && $onehot0(rs_hit_vec));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !rs_valid |-> !rs_mispredict);
endmodule

bind btb_predictor btb_checker #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_btb_checker (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_kind(lk_kind),
  .lk_taken(lk_taken), .lk_target(lk_target), .rs_valid(rs_valid), .rs_pc(rs_pc),
  .rs_kind(rs_kind), .rs_taken(rs_taken), .rs_target(rs_target),
  .rs_mispredict(rs_mispredict), .lk_hit_vec(lk_hit_vec), .rs_hit_vec(rs_hit_vec)
);

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
  localparam int AW = 16;
  localparam logic [1:0] K_REL = 2'b00, K_REG = 2'b01, K_ALW = 2'b10, K_NEV = 2'b11;
  localparam logic [AW-1:0] DSP = 16'h0010;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_pc = '0;
  logic [1:0]    lk_kind = '0;
  logic [AW-1:0] lk_disp = '0;
  logic          lk_taken;
  logic [AW-1:0] lk_target;
  logic          rs_valid = 1'b0;
  logic [AW-1:0] rs_pc = '0;
  logic [1:0]    rs_kind = '0;
  logic          rs_taken = 1'b0;
  logic [AW-1:0] rs_target = '0;
  logic          rs_mispredict;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  btb_predictor #(.ADDR_W(AW), .ENTRIES(16), .WAYS(4), .ALIGN_W(1)) dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_kind(lk_kind),
    .lk_disp(lk_disp), .lk_taken(lk_taken), .lk_target(lk_target),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_kind(rs_kind), .rs_taken(rs_taken),
    .rs_target(rs_target), .rs_mispredict(rs_mispredict)
  );

  function automatic logic [AW-1:0] pc_of(int s, int k);
    return AW'(((s * 16 + k + 1) << 3) | (s << 1));
  endfunction

  function automatic logic [AW-1:0] tgt_of(int s, int k);
    return AW'(16'h4000 + s * 256 + k * 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [AW-1:0] pc, input logic [1:0] k, input logic exp_t,
                      input logic [AW-1:0] exp_tg, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc; lk_kind = k; lk_disp = DSP;
    #1;
    chk(req, 32'(lk_taken), 32'(exp_t));
    chk(req, 32'(lk_target), 32'(exp_tg));
    lk_valid = 1'b0;
  endtask

  task automatic resolve(input logic [AW-1:0] pc, input logic [1:0] k, input logic tk,
                         input logic [AW-1:0] tg, input logic exp_mis, input string req);
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_kind = k; rs_taken = tk; rs_target = tg;
    #1;
    chk(req, 32'(rs_mispredict), 32'(exp_mis));
    @(posedge clk);
    #1;
    rs_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 / R2: empty table after reset, computed target on miss
    for (int s = 0; s < 4; s++) begin
      look(pc_of(s, 0), K_REG, 1'b0, pc_of(s, 0) + DSP, "R1");
      look(pc_of(s, 1), K_REL, 1'b0, pc_of(s, 1) + DSP, "R2");
    end
    // R12: idle resolve port
    @(negedge clk); #1;
    chk("R12", 32'(rs_mispredict), 32'd0);

    for (int s = 0; s < 4; s++) begin
      // fill the set: taken misses (R7), then hits (R3, R4)
      for (int k = 0; k < 4; k++) resolve(pc_of(s, k), K_REG, 1'b1, tgt_of(s, k), 1'b1, "R7");
      for (int k = 0; k < 4; k++) look(pc_of(s, k), K_REG, 1'b1, tgt_of(s, k), "R3");
      // fifth tag evicts the oldest
      resolve(pc_of(s, 4), K_REG, 1'b1, tgt_of(s, 4), 1'b1, "R7");
      look(pc_of(s, 0), K_REG, 1'b0, pc_of(s, 0) + DSP, "R10");
      for (int k = 1; k < 5; k++) look(pc_of(s, k), K_REG, 1'b1, tgt_of(s, k), "R10");
      // confirm k1 (same target: no mispredict), then sixth tag evicts k2
      resolve(pc_of(s, 1), K_REG, 1'b1, tgt_of(s, 1), 1'b0, "R5");
      resolve(pc_of(s, 5), K_REG, 1'b1, tgt_of(s, 5), 1'b1, "R7");
      look(pc_of(s, 2), K_REG, 1'b0, pc_of(s, 2) + DSP, "R10");
      look(pc_of(s, 1), K_REG, 1'b1, tgt_of(s, 1), "R10");
      look(pc_of(s, 3), K_REG, 1'b1, tgt_of(s, 3), "R10");
      look(pc_of(s, 4), K_REG, 1'b1, tgt_of(s, 4), "R10");
      look(pc_of(s, 5), K_REG, 1'b1, tgt_of(s, 5), "R10");
      // changed register target
      resolve(pc_of(s, 3), K_REG, 1'b1, tgt_of(s, 3) + 16'h0100, 1'b1, "R5");
      look(pc_of(s, 3), K_REG, 1'b1, tgt_of(s, 3) + 16'h0100, "R5");
      // not-taken hit invalidates; repeat misses quietly
      resolve(pc_of(s, 1), K_REG, 1'b0, '0, 1'b1, "R6");
      look(pc_of(s, 1), K_REG, 1'b0, pc_of(s, 1) + DSP, "R6");
      resolve(pc_of(s, 1), K_REG, 1'b0, '0, 1'b0, "R6");
      // invalid way is filled before the LRU way (k4 is oldest)
      resolve(pc_of(s, 6), K_REG, 1'b1, tgt_of(s, 6), 1'b1, "R7");
      look(pc_of(s, 4), K_REG, 1'b1, tgt_of(s, 4), "R10");
      look(pc_of(s, 5), K_REG, 1'b1, tgt_of(s, 5), "R10");
      look(pc_of(s, 6), K_REG, 1'b1, tgt_of(s, 6), "R10");
      look(pc_of(s, 1), K_REG, 1'b0, pc_of(s, 1) + DSP, "R6");
      // never-taken class overrides a resident entry and leaves it intact
      look(pc_of(s, 4), K_NEV, 1'b0, pc_of(s, 4) + DSP, "R9");
      resolve(pc_of(s, 4), K_NEV, 1'b1, tgt_of(s, 4), 1'b1, "R9");
      resolve(pc_of(s, 4), K_NEV, 1'b0, '0, 1'b0, "R9");
      look(pc_of(s, 4), K_REG, 1'b1, tgt_of(s, 4), "R9");
      // always-taken class bypasses the table
      look(pc_of(s, 7), K_ALW, 1'b1, pc_of(s, 7) + DSP, "R8");
      resolve(pc_of(s, 7), K_ALW, 1'b0, '0, 1'b1, "R8");
      resolve(pc_of(s, 7), K_ALW, 1'b1, pc_of(s, 7) + DSP, 1'b0, "R8");
      look(pc_of(s, 7), K_REG, 1'b0, pc_of(s, 7) + DSP, "R8");
      look(pc_of(s, 4), K_REG, 1'b1, tgt_of(s, 4), "R8");
    end

    // R1: mid-run reset empties the table
    do_reset();
    look(pc_of(0, 4), K_REG, 1'b0, pc_of(0, 4) + DSP, "R1");
    look(pc_of(3, 6), K_REG, 1'b0, pc_of(3, 6) + DSP, "R1");

    // R4: relative entries use computed targets, no target check on resolve
    resolve(pc_of(1, 2), K_REL, 1'b1, 16'h1234, 1'b1, "R7");
    look(pc_of(1, 2), K_REL, 1'b1, pc_of(1, 2) + DSP, "R4");
    resolve(pc_of(1, 2), K_REL, 1'b1, 16'h5678, 1'b0, "R4");

    // R11: same-cycle lookup and update of one address
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc_of(2, 3); lk_kind = K_REG; lk_disp = DSP;
    rs_valid = 1'b1; rs_pc = pc_of(2, 3); rs_kind = K_REG; rs_taken = 1'b1; rs_target = 16'h7770;
    #1;
    chk("R11", 32'(lk_taken), 32'd0);
    chk("R11", 32'(lk_target), 32'(pc_of(2, 3) + DSP));
    chk("R11", 32'(rs_mispredict), 32'd1);
    @(posedge clk);
    #1;
    rs_valid = 1'b0;
    #1;
    chk("R11", 32'(lk_taken), 32'd1);
    chk("R11", 32'(lk_target), 32'h7770);
    lk_valid = 1'b0;

    @(negedge clk); #1;
    chk("R12", 32'(rs_mispredict), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule